// File: doc/BRIEF.md
# Display Power and Initialisation Sequencer

This block brings an external display controller up from cold, switches its supply stages on and off later, and leaves it ready to accept pixel data. It runs fixed lists of register operations held in a constant table. Each table entry carries an operation kind, an 8-bit register index, a 16-bit value, a delay in milliseconds and an end-of-list flag. The block issues one entry at a time to a register access master, which owns the physical serial link, and waits for that master to report completion. When an entry asks for a delay, the block counts the milliseconds on a free-running microsecond tick before it moves to the next entry.

A bring-up job always reads the identity register first. It continues only if that identity matches. It then runs the configuration writes, the supply power-up stages, the gamma and window writes, and finally an index-only operation that points the controller at its pixel memory. Separate power-on and power-off jobs reuse the supply stages. The block keeps the current power state. It accepts a power command only when the command would change that state, and it updates the state only when a job finishes cleanly. Any access fault or identity mismatch stops the job at the failing entry and raises a sticky error flag.

Top module: `panel_bringup_seq`

## Requirements
- R1: After reset, busy, error, powered and acc_req are all low.
- R2: The first request of a bring-up job is a read (acc_op = 1) of index 0x00. If the returned word ANDed with 0xFFF0 differs from 0x9220, the job ends at once with error high and no further request; the low four bits of the word are ignored.
- R3: A bring-up job issues, in this order, writes (acc_op = 0): 0x0001 to 0x00; 0x691B to 0x01; 0x0700 to 0x02; 0x1030 to 0x03; 0x0110 to 0x0C. It then issues the power-up writes of R6, then 0x0302, 0x0407, 0x0304, 0x0203, 0x0706, 0x0407, 0x0706, 0x0000, 0x0C06, 0x0F00 to 0x30 through 0x39. It then writes 0xDB00 to 0x42, 0xDB00 to 0x43, 0xAF00 to 0x44 and 0xDB00 to 0x45. Each request stays stable until acc_done.
- R4: The last request of a bring-up job is index-only (acc_op = 2) to 0x22. After it completes, busy falls and powered is high.
- R5: After an entry with a delay of D ms completes, the next request is raised only after exactly D×TICKS_PER_MS further us_tick pulses (one more is tolerated). The delays are 10 ms after the write to 0x00 and after each write to 0x10, and 40 ms after each write to 0x12 and 0x13.
- R6: The power-off job writes 0x0000 to 0x10, 0x11, 0x12 and 0x13, and then clears powered. The power-on job runs the same four writes, then writes 0x080F to 0x56, 0x4240 to 0x10, 0x0000 to 0x11, 0x0014 to 0x12 and 0x1319 to 0x13, and then sets powered.
- R7: power_on while powered is high, or power_off while powered is low, starts nothing: no request is issued and busy stays low.
- R8: Commands that arrive while busy is high are ignored, and the running job continues unchanged.
- R9: acc_err on a completion stops the job at that entry with error high and powered unchanged. error stays high until the next command is accepted, which clears it.
- R10: When commands arrive in the same idle cycle, start_init wins over both power commands. When power_on and power_off arrive together, the one that changes the power state runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_init | input | 1 | Start a full bring-up job |
| power_on | input | 1 | Request the power-on job |
| power_off | input | 1 | Request the power-off job |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| acc_req | output | 1 | Request to the access master, held until acc_done |
| acc_op | output | 2 | 0 write, 1 read, 2 index-only |
| acc_index | output | 8 | Register index |
| acc_wdata | output | 16 | Write value |
| acc_done | input | 1 | Access master finished the request |
| acc_err | input | 1 | Access master reports a fault with acc_done |
| acc_rdata | input | 16 | Read data, valid with acc_done |
| busy | output | 1 | A job is running |
| error | output | 1 | Sticky job failure flag |
| powered | output | 1 | Tracked power state of the display |

## Verification
The collisions of interest happen at command acceptance. start_init, power_on and power_off can arrive in the same cycle, and a command can arrive while a job is running. The bench raises all three commands in one cycle and then both power commands together. It judges the result by the exact request stream that follows, which the scoreboard compares entry by entry. It also pulses start_init and power_off in the middle of a power-on job. It checks that the queued stream still drains with no extra request and that powered ends high.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int IDX_W     = 8;
    localparam int VAL_W     = 16;
    localparam int DLY_W     = 8;
    localparam int ROM_DEPTH = 43;
    localparam int PTR_W     = $clog2(ROM_DEPTH);

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_INDEX = 2'd2
    } acc_op_e;

    typedef enum logic [1:0] {
        JOB_INIT,
        JOB_UP,
        JOB_DOWN
    } job_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_STEP
    } seq_state_e;

    typedef struct packed {
        logic             last;
        acc_op_e          op;
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] val;
        logic [DLY_W-1:0] dly_ms;
    } seq_entry_t;

    localparam logic [PTR_W-1:0] BASE_INIT = PTR_W'(0);
    localparam logic [PTR_W-1:0] BASE_UP   = PTR_W'(30);
    localparam logic [PTR_W-1:0] BASE_DOWN = PTR_W'(39);
    localparam logic [PTR_W-1:0] END_UP    = PTR_W'(38);
    localparam logic [PTR_W-1:0] END_DOWN  = PTR_W'(ROM_DEPTH - 1);
    localparam logic [PTR_W-1:0] UP_SHIFT  = PTR_W'(24);
    localparam logic [PTR_W-1:0] DN_SHIFT  = PTR_W'(33);

    localparam logic [VAL_W-1:0] ID_MASK   = 16'hFFF0;
    localparam logic [VAL_W-1:0] ID_EXPECT = 16'h9220;

    function automatic seq_entry_t mk(input acc_op_e op, input logic [7:0] idx,
                                      input logic [15:0] val, input logic [7:0] dly);
        seq_entry_t e;
        e.last   = 1'b0;
        e.op     = op;
        e.idx    = idx;
        e.val    = val;
        e.dly_ms = dly;
        return e;
    endfunction

    function automatic logic [15:0] gamma_val(input logic [3:0] k);
        case (k)
            4'd0:    return 16'h0302;
            4'd1:    return 16'h0407;
            4'd2:    return 16'h0304;
            4'd3:    return 16'h0203;
            4'd4:    return 16'h0706;
            4'd5:    return 16'h0407;
            4'd6:    return 16'h0706;
            4'd7:    return 16'h0000;
            4'd8:    return 16'h0C06;
            default: return 16'h0F00;
        endcase
    endfunction

    function automatic logic [15:0] window_val(input logic [1:0] k);
        return (k == 2'd2) ? 16'hAF00 : 16'hDB00;
    endfunction

    // Bring-up list; entries 6..14 double as the power-up list and 6..9 as power-down.
    function automatic seq_entry_t init_entry(input logic [PTR_W-1:0] a);
        seq_entry_t e;
        case (a)
            6'd0:  e = mk(OP_READ,  8'h00, 16'h0000, 8'd0);
            6'd1:  e = mk(OP_WRITE, 8'h00, 16'h0001, 8'd10);
            6'd2:  e = mk(OP_WRITE, 8'h01, 16'h691B, 8'd0);
            6'd3:  e = mk(OP_WRITE, 8'h02, 16'h0700, 8'd0);
            6'd4:  e = mk(OP_WRITE, 8'h03, 16'h1030, 8'd0);
            6'd5:  e = mk(OP_WRITE, 8'h0C, 16'h0110, 8'd0);
            6'd6:  e = mk(OP_WRITE, 8'h10, 16'h0000, 8'd10);
            6'd7:  e = mk(OP_WRITE, 8'h11, 16'h0000, 8'd0);
            6'd8:  e = mk(OP_WRITE, 8'h12, 16'h0000, 8'd40);
            6'd9:  e = mk(OP_WRITE, 8'h13, 16'h0000, 8'd40);
            6'd10: e = mk(OP_WRITE, 8'h56, 16'h080F, 8'd0);
            6'd11: e = mk(OP_WRITE, 8'h10, 16'h4240, 8'd10);
            6'd12: e = mk(OP_WRITE, 8'h11, 16'h0000, 8'd0);
            6'd13: e = mk(OP_WRITE, 8'h12, 16'h0014, 8'd40);
            6'd14: e = mk(OP_WRITE, 8'h13, 16'h1319, 8'd40);
            6'd29: begin
                e = mk(OP_INDEX, 8'h22, 16'h0000, 8'd0);
                e.last = 1'b1;
            end
            default: begin
                if (a >= 6'd15 && a <= 6'd24) begin
                    e = mk(OP_WRITE, 8'h30 + 8'(a - 6'd15),
                           gamma_val(4'(a - 6'd15)), 8'd0);
                end else begin
                    e = mk(OP_WRITE, 8'h42 + 8'(a - 6'd25),
                           window_val(2'(a - 6'd25)), 8'd0);
                end
            end
        endcase
        return e;
    endfunction

    function automatic seq_entry_t rom_entry(input logic [PTR_W-1:0] a);
        seq_entry_t e;
        if (a >= BASE_DOWN) begin
            e = init_entry(a - DN_SHIFT);
            e.last = (a == END_DOWN);
        end else if (a >= BASE_UP) begin
            e = init_entry(a - UP_SHIFT);
            e.last = (a == END_UP);
        end else begin
            e = init_entry(a);
        end
        return e;
    endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
    import panel_seq_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    output seq_entry_t       ent
);

    assign ent = rom_entry(ptr);

endmodule

// File: rtl/panel_seq_delay.sv
module panel_seq_delay
    import panel_seq_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_ms,
    input  logic             tick,
    output logic             running
);

    localparam int TK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [TK_W-1:0] TK_LAST = TK_W'(TICKS_PER_MS - 1);

    logic [DLY_W-1:0] ms_cnt;
    logic [TK_W-1:0]  tk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_cnt <= '0;
            tk_cnt <= '0;
        end else if (load) begin
            ms_cnt <= load_ms;
            tk_cnt <= '0;
        end else if (tick && ms_cnt != '0) begin
            if (tk_cnt == TK_LAST) begin
                tk_cnt <= '0;
                ms_cnt <= ms_cnt - 1'b1;
            end else begin
                tk_cnt <= tk_cnt + 1'b1;
            end
        end
    end

    assign running = (ms_cnt != '0);

    AST_DELAY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(ms_cnt)); // R5

    AST_DELAY_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && ms_cnt == '0) |=> (ms_cnt == '0)); // R5

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
    import panel_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_init,
    input  logic             power_on,
    input  logic             power_off,
    input  seq_entry_t       ent,
    input  logic             dly_running,
    input  logic             acc_done,
    input  logic             acc_err,
    input  logic [VAL_W-1:0] acc_rdata,
    output logic [PTR_W-1:0] ptr,
    output logic             dly_load,
    output logic [DLY_W-1:0] dly_ms,
    output logic             acc_req,
    output logic [1:0]       acc_op,
    output logic [IDX_W-1:0] acc_index,
    output logic [VAL_W-1:0] acc_wdata,
    output logic             busy,
    output logic             error,
    output logic             powered
);

    seq_state_e state;
    job_e       job;
    logic       err_q;
    logic       pwr_q;

    logic idle, take_init, take_up, take_down, take_any;
    logic id_bad, fail_now, ok_done;

    assign idle      = (state == ST_IDLE);
    assign take_init = idle && start_init;
    assign take_up   = idle && !start_init && power_on && !pwr_q;
    assign take_down = idle && !start_init && !take_up && power_off && pwr_q;
    assign take_any  = take_init || take_up || take_down;

    assign id_bad   = (ent.op == OP_READ) && ((acc_rdata & ID_MASK) != ID_EXPECT);
    assign fail_now = (state == ST_ISSUE) && acc_done && (acc_err || id_bad);
    assign ok_done  = (state == ST_ISSUE) && acc_done && !fail_now;

    assign dly_load = ok_done && (ent.dly_ms != '0);
    assign dly_ms   = ent.dly_ms;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= JOB_INIT;
            ptr   <= '0;
            err_q <= 1'b0;
            pwr_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take_any) begin
                        err_q <= 1'b0;
                        state <= ST_ISSUE;
                    end
                    if (take_init) begin
                        job <= JOB_INIT;
                        ptr <= BASE_INIT;
                    end else if (take_up) begin
                        job <= JOB_UP;
                        ptr <= BASE_UP;
                    end else if (take_down) begin
                        job <= JOB_DOWN;
                        ptr <= BASE_DOWN;
                    end
                end
                ST_ISSUE: begin
                    if (fail_now) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else if (dly_load) begin
                        state <= ST_WAIT;
                    end else if (ok_done) begin
                        state <= ST_STEP;
                    end
                end
                ST_WAIT: begin
                    if (!dly_running) begin
                        state <= ST_STEP;
                    end
                end
                default: begin
                    if (ent.last) begin
                        pwr_q <= (job != JOB_DOWN);
                        state <= ST_IDLE;
                    end else begin
                        ptr   <= ptr + 1'b1;
                        state <= ST_ISSUE;
                    end
                end
            endcase
        end
    end

    assign acc_req   = (state == ST_ISSUE);
    assign acc_op    = ent.op;
    assign acc_index = ent.idx;
    assign acc_wdata = ent.val;
    assign busy      = !idle;
    assign error     = err_q;
    assign powered   = pwr_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_done) |=> (acc_req && $stable(acc_index)
                                    && $stable(acc_wdata) && $stable(acc_op))); // R3

    AST_ID_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && job == JOB_INIT) |-> (acc_op == 2'd1 && acc_index == 8'h00)); // R2

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> !busy); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(error) |-> $past(start_init || power_on || power_off)); // R9

    AST_PWR_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(powered) |-> ($past(busy) && !busy && !error)); // R6

    AST_NO_REQ_IN_DELAY: assert property (@(posedge clk) disable iff (rst)
        dly_running |-> !acc_req); // R5

endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq
    import panel_seq_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_init,
    input  logic        power_on,
    input  logic        power_off,
    input  logic        us_tick,
    output logic        acc_req,
    output logic [1:0]  acc_op,
    output logic [7:0]  acc_index,
    output logic [15:0] acc_wdata,
    input  logic        acc_done,
    input  logic        acc_err,
    input  logic [15:0] acc_rdata,
    output logic        busy,
    output logic        error,
    output logic        powered
);

    logic [PTR_W-1:0] ptr;
    seq_entry_t       ent;
    logic             dly_load;
    logic [DLY_W-1:0] dly_ms;
    logic             dly_running;

    panel_seq_rom u_rom (
        .ptr (ptr),
        .ent (ent)
    );

    panel_seq_delay #(
        .TICKS_PER_MS (TICKS_PER_MS)
    ) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (dly_load),
        .load_ms (dly_ms),
        .tick    (us_tick),
        .running (dly_running)
    );

    panel_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_init  (start_init),
        .power_on    (power_on),
        .power_off   (power_off),
        .ent         (ent),
        .dly_running (dly_running),
        .acc_done    (acc_done),
        .acc_err     (acc_err),
        .acc_rdata   (acc_rdata),
        .ptr         (ptr),
        .dly_load    (dly_load),
        .dly_ms      (dly_ms),
        .acc_req     (acc_req),
        .acc_op      (acc_op),
        .acc_index   (acc_index),
        .acc_wdata   (acc_wdata),
        .busy        (busy),
        .error       (error),
        .powered     (powered)
    );

endmodule

// File: tb/sim_panel_bringup_seq.sv
module sim_panel_bringup_seq;

    localparam int TPM  = 2;
    localparam int NOGAP = 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_init = 1'b0, power_on = 1'b0, power_off = 1'b0, us_tick = 1'b0;
    logic        acc_req, busy, error, powered;
    logic [1:0]  acc_op;
    logic [7:0]  acc_index;
    logic [15:0] acc_wdata;
    logic        acc_done = 1'b0, acc_err = 1'b0;
    logic [15:0] acc_rdata = 16'h0000;

    always #4 clk = ~clk;

    panel_bringup_seq #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst(rst), .start_init(start_init), .power_on(power_on),
        .power_off(power_off), .us_tick(us_tick), .acc_req(acc_req),
        .acc_op(acc_op), .acc_index(acc_index), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_err(acc_err), .acc_rdata(acc_rdata),
        .busy(busy), .error(error), .powered(powered)
    );

    typedef struct {
        logic [1:0]  op;
        logic [7:0]  idx;
        logic [15:0] val;
        int          gap;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          n_chk = 0, n_bad = 0;
    int          err_at = -1, resp_n = 0, tcnt = 0;
    logic [15:0] id_word = 16'h9221;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [7:0] idx,
                        input logic [15:0] val, input int gap, input string tag);
        exp_t e;
        e.op = op; e.idx = idx; e.val = val; e.gap = gap; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_down(input int gap0);
        push(2'd0, 8'h10, 16'h0000, gap0, "R6");
        push(2'd0, 8'h11, 16'h0000, 10,   "R6");
        push(2'd0, 8'h12, 16'h0000, 0,    "R6");
        push(2'd0, 8'h13, 16'h0000, 40,   "R6");
    endtask

    task automatic push_up(input int gap0);
        push_down(gap0);
        push(2'd0, 8'h56, 16'h080F, 40, "R6");
        push(2'd0, 8'h10, 16'h4240, 0,  "R6");
        push(2'd0, 8'h11, 16'h0000, 10, "R6");
        push(2'd0, 8'h12, 16'h0014, 0,  "R6");
        push(2'd0, 8'h13, 16'h1319, 40, "R6");
    endtask

    task automatic push_init();
        logic [15:0] gam [10] = '{16'h0302, 16'h0407, 16'h0304, 16'h0203, 16'h0706,
                                  16'h0407, 16'h0706, 16'h0000, 16'h0C06, 16'h0F00};
        push(2'd1, 8'h00, 16'h0000, NOGAP, "R2");
        push(2'd0, 8'h00, 16'h0001, 0,  "R3");
        push(2'd0, 8'h01, 16'h691B, 10, "R3");
        push(2'd0, 8'h02, 16'h0700, 0,  "R3");
        push(2'd0, 8'h03, 16'h1030, 0,  "R3");
        push(2'd0, 8'h0C, 16'h0110, 0,  "R3");
        push_up(0);
        for (int k = 0; k < 10; k++)
            push(2'd0, 8'h30 + 8'(k), gam[k], (k == 0) ? 40 : 0, "R3");
        push(2'd0, 8'h42, 16'hDB00, 0, "R3");
        push(2'd0, 8'h43, 16'hDB00, 0, "R3");
        push(2'd0, 8'h44, 16'hAF00, 0, "R3");
        push(2'd0, 8'h45, 16'hDB00, 0, "R3");
        push(2'd2, 8'h22, 16'h0000, 0, "R4");
    endtask

    // microsecond tick: one cycle in three
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (acc_done) tcnt <= 0;
        else if (us_tick) tcnt <= tcnt + 1;
    end

    // access master model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && acc_req) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected request", {acc_op, acc_index}, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(acc_op == e.op, e.tag, "op", acc_op, e.op);
                    chk(acc_index == e.idx, e.tag, "index", acc_index, e.idx);
                    chk(acc_wdata == e.val, e.tag, "value", acc_wdata, e.val);
                    if (e.gap != NOGAP)
                        chk(tcnt >= e.gap * TPM && tcnt <= e.gap * TPM + 1,
                            "R5", "ticks before request", tcnt, e.gap * TPM);
                end
                repeat (2) @(negedge clk);
                acc_rdata = id_word;
                acc_err   = (resp_n == err_at);
                resp_n++;
                acc_done  = 1'b1;
                @(negedge clk);
                acc_done  = 1'b0;
                acc_err   = 1'b0;
            end
        end
    end

    task automatic pulse(input bit si, input bit pon, input bit poff);
        @(negedge clk);
        start_init = si; power_on = pon; power_off = poff;
        @(negedge clk);
        start_init = 1'b0; power_on = 1'b0; power_off = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R3", "missing requests", expq.size(), 0);
        expq.delete();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected idle");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0,    "R1", "busy", busy, 0);
        chk(error == 1'b0,   "R1", "error", error, 0);
        chk(powered == 1'b0, "R1", "powered", powered, 0);
        chk(acc_req == 1'b0, "R1", "acc_req", acc_req, 0);

        // full bring-up, ID low nibble ignored (R2, R3, R4, R5)
        push_init();
        pulse(1, 0, 0);
        wait_idle();
        chk(powered == 1'b1, "R4", "powered after init", powered, 1);
        chk(error == 1'b0,   "R2", "error after good id", error, 0);

        // repeated power_on ignored (R7)
        pulse(0, 1, 0);
        chk(busy == 1'b0, "R7", "busy on redundant power_on", busy, 0);
        repeat (20) @(negedge clk);

        // power-off (R6)
        push_down(NOGAP);
        pulse(0, 0, 1);
        wait_idle();
        chk(powered == 1'b0, "R6", "powered after off", powered, 0);

        // repeated power_off ignored (R7)
        pulse(0, 0, 1);
        chk(busy == 1'b0, "R7", "busy on redundant power_off", busy, 0);
        repeat (20) @(negedge clk);
        chk(powered == 1'b0, "R7", "powered after redundant off", powered, 0);

        // power-on with commands during busy (R6, R8)
        push_up(NOGAP);
        pulse(0, 1, 0);
        repeat (30) @(negedge clk);
        pulse(1, 0, 1);
        wait_idle();
        chk(powered == 1'b1, "R8", "powered after on", powered, 1);

        // identity mismatch (R2, R9)
        id_word = 16'h9320;
        push(2'd1, 8'h00, 16'h0000, NOGAP, "R2");
        pulse(1, 0, 0);
        wait_idle();
        chk(error == 1'b1,   "R2", "error on bad id", error, 1);
        chk(powered == 1'b1, "R9", "powered kept on bad id", powered, 1);
        repeat (20) @(negedge clk);
        chk(error == 1'b1,   "R9", "error sticky", error, 1);

        // access fault mid-job (R9)
        id_word = 16'h9221;
        err_at  = resp_n + 1;
        push(2'd0, 8'h10, 16'h0000, NOGAP, "R9");
        push(2'd0, 8'h11, 16'h0000, 10,    "R9");
        pulse(0, 0, 1);
        chk(error == 1'b0,   "R9", "error cleared by command", error, 0);
        wait_idle();
        err_at = -1;
        chk(error == 1'b1,   "R9", "error on access fault", error, 1);
        chk(powered == 1'b1, "R9", "powered kept on fault", powered, 1);

        // all three commands at once: bring-up wins (R10)
        push_init();
        pulse(1, 1, 1);
        wait_idle();
        chk(powered == 1'b1, "R10", "powered after combined start", powered, 1);
        chk(error == 1'b0,   "R10", "error after combined start", error, 0);

        // both power commands while on: power-off runs (R10)
        push_down(NOGAP);
        pulse(0, 1, 1);
        wait_idle();
        chk(powered == 1'b0, "R10", "powered after both power cmds", powered, 0);

        finish_run();
    end

endmodule